// File: doc/BRIEF.md
# Two-wire serial debug host transaction engine

This block is the host side of a two-wire serial debug link. It has a clock output and one bidirectional data line, made of an output value, an output enable and an input. A controller hands it one request at a time on a parallel interface. The request names the target port (debug or access), the direction, a 2-bit register address and a 32-bit write word. The engine frames the request as a packet with header parity, direction turnarounds, a 3-bit acknowledge from the target and an even-parity data phase. It then returns the acknowledge, the read word and a parity-error indication.

The engine makes the debug clock by dividing the system clock. Each half period lasts `CLK_DIV` system cycles. The host launches every bit while the debug clock is low, starting at its falling edge, and samples the line on the rising edge. After each packet the engine drives a configurable number of low idle bits (`IDLE_CYCLES`) and then pulses `done`. Retrying after a wait or fault response, link bring-up and memory access sequencing belong to the controller.

Top module: `swdh_engine`

## Requirements
- R1: The first 8 debug clock bits of a packet are driven by the host, least significant bit first. Bit 0 is 1. Bit 1 is `req_ap`. Bit 2 is `req_rd`. Bits 3 and 4 are `req_addr[0]` and `req_addr[1]`. Bit 5 is parity. Bit 6 is 0 and bit 7 is 1.
- R2: The parity bit at header position 5 makes header bits 1 through 5 hold an even number of ones.
- R3: The host releases the data line for one turnaround bit and then for three acknowledge bits. The first acknowledge bit sampled becomes `rsp_ack[0]`. The value 3'b001 means OK, and `rsp_ack_err` stays 0 for it.
- R4: Any acknowledge other than 3'b001 sets `rsp_ack_err`. No data phase follows. One released turnaround bit is followed directly by the idle bits, and `rsp_rdata` and `rsp_par_err` stay 0.
- R5: On an OK write, the host releases the line for one turnaround bit. It then drives `req_wdata` over 32 bits, least significant bit first, followed by one bit equal to the XOR of those 32 bits.
- R6: On an OK read, the line stays released while 32 data bits are sampled (least significant bit first), then one parity bit, then one turnaround bit. The word appears on `rsp_rdata`.
- R7: `rsp_par_err` is 1 after a read exactly when the received parity bit differs from the XOR of the 32 received bits. It is never set by a write.
- R8: `swdio_out` and `swdio_oe` change only while `swclk` is low. `swclk` stays low while the engine is idle, and in reset or idle the line is driven low.
- R9: After each packet the host drives `IDLE_CYCLES` further low bits. The packet is then complete, with no further clock bits.
- R10: A request is accepted when `req_valid` is high and `busy` is low. `busy` stays high until a one-cycle `done` pulse, and requests made while busy are ignored.
- R11: Each debug clock half period lasts `CLK_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_ap | input | 1 | 1 selects the access port, 0 the debug port |
| req_rd | input | 1 | 1 for a read, 0 for a write |
| req_addr | input | 2 | Register address bits [3:2] |
| req_wdata | input | 32 | Write word |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | One-cycle pulse at the end of a packet |
| rsp_rdata | output | 32 | Word received on a read |
| rsp_ack | output | 3 | Acknowledge received from the target |
| rsp_ack_err | output | 1 | Acknowledge was not OK |
| rsp_par_err | output | 1 | Read parity mismatch |
| swclk | output | 1 | Debug clock |
| swdio_out | output | 1 | Data line value driven by the host |
| swdio_oe | output | 1 | Data line output enable |
| swdio_in | input | 1 | Data line value seen at the pad |

## Verification
The bench builds the engine with `CLK_DIV` = 2 and `IDLE_CYCLES` = 3. The counter-based clock divider is therefore in use, and half-period timing can be measured as exactly two system cycles. A short idle tail keeps every packet at 49 or 16 debug bits. Each bit can then be logged and compared by position, covering the header, every release window, the ack-error early exit and the trailing idle bits.

// File: rtl/swdh_pkg.sv
`timescale 1ns/1ps
package swdh_pkg;

   localparam int SWDH_HDR_BITS  = 8;
   localparam int SWDH_ACK_BITS  = 3;
   localparam int SWDH_WORD_BITS = 32;
   localparam logic [SWDH_ACK_BITS-1:0] SWDH_ACK_OK = 3'b001;

   // packet phases, one per framing segment on the wire
   typedef enum logic [3:0] {
      PH_IDLE,
      PH_HDR,
      PH_TRN_A,
      PH_ACK,
      PH_TRN_B,
      PH_WDAT,
      PH_WPAR,
      PH_RDAT,
      PH_RPAR,
      PH_TRN_C,
      PH_GAP
   } swdh_phase_e;

   // fields that enter the request header
   typedef struct packed {
      logic       ap;
      logic       rd;
      logic [1:0] addr;
   } swdh_hdr_req_t;

endpackage

// File: rtl/swdh_hdr.sv
`timescale 1ns/1ps
module swdh_hdr
   import swdh_pkg::*;
(
   input  swdh_hdr_req_t              req,
   output logic [SWDH_HDR_BITS-1:0]   hdr
);

   logic par;

   // even parity over port select, direction and both address bits
   assign par = req.ap ^ req.rd ^ req.addr[0] ^ req.addr[1];

   // bit 0 leaves the wire first
   assign hdr = {1'b1,        // park
                 1'b0,        // stop
                 par,
                 req.addr[1],
                 req.addr[0],
                 req.rd,
                 req.ap,
                 1'b1};       // start

endmodule

// File: rtl/swdh_clkgen.sv
`timescale 1ns/1ps
module swdh_clkgen #(
   parameter int CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic swclk,
   output logic rise_now,
   output logic fall_now
);

   if (CLK_DIV < 1) begin : g_bad_div
      $error("swdh_clkgen: CLK_DIV must be at least 1");
   end

   logic swclk_q;
   logic wrap;

   generate
      if (CLK_DIV == 1) begin : g_fast
         // every system cycle is one half period
         assign wrap = run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       swclk_q <= 1'b0;
            else if (!run)    swclk_q <= 1'b0;
            else              swclk_q <= ~swclk_q;
         end
      end else begin : g_div
         localparam int CW = $clog2(CLK_DIV);
         localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
         logic [CW-1:0] cnt_q;
         assign wrap = run && (cnt_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q   <= '0;
               swclk_q <= 1'b0;
            end else if (!run) begin
               cnt_q   <= '0;
               swclk_q <= 1'b0;
            end else if (wrap) begin
               cnt_q   <= '0;
               swclk_q <= ~swclk_q;
            end else begin
               cnt_q   <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign swclk    = swclk_q;
   assign rise_now = wrap & ~swclk_q;
   assign fall_now = wrap &  swclk_q;

   AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !swclk); // R8

endmodule

// File: rtl/swdh_seq.sv
`timescale 1ns/1ps
module swdh_seq
   import swdh_pkg::*;
#(
   parameter int IDLE_CYCLES = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic                       req_rd,
   input  logic [SWDH_WORD_BITS-1:0]  req_wdata,
   input  logic [SWDH_HDR_BITS-1:0]   hdr,
   input  logic                       rise_now,
   input  logic                       fall_now,
   input  logic                       swdio_in,
   output logic                       busy,
   output logic                       done,
   output logic [SWDH_WORD_BITS-1:0]  rsp_rdata,
   output logic [SWDH_ACK_BITS-1:0]   rsp_ack,
   output logic                       rsp_ack_err,
   output logic                       rsp_par_err,
   output logic                       swdio_out,
   output logic                       swdio_oe
);

   if (IDLE_CYCLES < 0 || IDLE_CYCLES > 65535) begin : g_bad_idle
      $error("swdh_seq: IDLE_CYCLES out of range");
   end

   localparam int MAXLEN = (IDLE_CYCLES > SWDH_WORD_BITS) ? IDLE_CYCLES : SWDH_WORD_BITS;
   localparam int BCW    = $clog2(MAXLEN);
   localparam int TXW    = SWDH_HDR_BITS + SWDH_WORD_BITS;

   swdh_phase_e                 phase_q, phase_nx, tail_ph;
   logic [BCW-1:0]              bit_q, last_idx;
   logic [TXW-1:0]              tx_q;
   logic [SWDH_WORD_BITS-1:0]   rx_q, rdata_q;
   logic [SWDH_ACK_BITS-1:0]    ack_q;
   logic                        rd_q, wpar_q, ackerr_q, parerr_q, done_q;
   logic                        accept, bit_end;

   assign busy   = (phase_q != PH_IDLE);
   assign accept = req_valid && !busy;

   // phase after the last data-carrying segment: idle tail or straight to done
   generate
      if (IDLE_CYCLES > 0) begin : g_gap
         assign tail_ph = PH_GAP;
      end else begin : g_nogap
         assign tail_ph = PH_IDLE;
      end
   endgenerate

   // index of the final bit in the current phase
   always_comb begin
      case (phase_q)
         PH_HDR:           last_idx = BCW'(SWDH_HDR_BITS - 1);
         PH_ACK:           last_idx = BCW'(SWDH_ACK_BITS - 1);
         PH_WDAT, PH_RDAT: last_idx = BCW'(SWDH_WORD_BITS - 1);
         PH_GAP:           last_idx = BCW'(IDLE_CYCLES - 1);
         default:          last_idx = '0;
      endcase
   end

   assign bit_end = fall_now && (bit_q == last_idx);

   always_comb begin
      case (phase_q)
         PH_HDR:   phase_nx = PH_TRN_A;
         PH_TRN_A: phase_nx = PH_ACK;
         PH_ACK:   phase_nx = (ack_q != SWDH_ACK_OK) ? PH_TRN_C :
                              (rd_q ? PH_RDAT : PH_TRN_B);
         PH_TRN_B: phase_nx = PH_WDAT;
         PH_WDAT:  phase_nx = PH_WPAR;
         PH_WPAR:  phase_nx = tail_ph;
         PH_RDAT:  phase_nx = PH_RPAR;
         PH_RPAR:  phase_nx = PH_TRN_C;
         PH_TRN_C: phase_nx = tail_ph;
         default:  phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         bit_q    <= '0;
         tx_q     <= '0;
         rx_q     <= '0;
         rdata_q  <= '0;
         ack_q    <= '0;
         rd_q     <= 1'b0;
         wpar_q   <= 1'b0;
         ackerr_q <= 1'b0;
         parerr_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            phase_q  <= PH_HDR;
            bit_q    <= '0;
            tx_q     <= {req_wdata, hdr};
            wpar_q   <= ^req_wdata;
            rd_q     <= req_rd;
            ack_q    <= '0;
            rx_q     <= '0;
            rdata_q  <= '0;
            ackerr_q <= 1'b0;
            parerr_q <= 1'b0;
         end else begin
            if (rise_now) begin
               case (phase_q)
                  PH_ACK:  ack_q <= {swdio_in, ack_q[SWDH_ACK_BITS-1:1]};
                  PH_RDAT: rx_q  <= {swdio_in, rx_q[SWDH_WORD_BITS-1:1]};
                  PH_RPAR: begin
                     rdata_q  <= rx_q;
                     parerr_q <= swdio_in ^ (^rx_q);
                  end
                  default: ;
               endcase
            end
            if (fall_now) begin
               if (phase_q == PH_HDR || phase_q == PH_WDAT)
                  tx_q <= tx_q >> 1;
               if (bit_end) begin
                  bit_q   <= '0;
                  phase_q <= phase_nx;
                  if (phase_q == PH_ACK)
                     ackerr_q <= (ack_q != SWDH_ACK_OK);
                  if (phase_nx == PH_IDLE)
                     done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   // line drive: host owns the line in header, write data, write parity and idle
   always_comb begin
      case (phase_q)
         PH_HDR, PH_WDAT: begin swdio_out = tx_q[0]; swdio_oe = 1'b1; end
         PH_WPAR:         begin swdio_out = wpar_q;  swdio_oe = 1'b1; end
         PH_IDLE, PH_GAP: begin swdio_out = 1'b0;    swdio_oe = 1'b1; end
         default:         begin swdio_out = 1'b0;    swdio_oe = 1'b0; end
      endcase
   end

   assign done        = done_q;
   assign rsp_rdata   = rdata_q;
   assign rsp_ack     = ack_q;
   assign rsp_ack_err = ackerr_q;
   assign rsp_par_err = parerr_q;

   AST_DATA_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_WDAT || phase_q == PH_RDAT) |-> (ack_q == SWDH_ACK_OK)); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R10
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy); // R10
   AST_PARERR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_par_err |-> rd_q); // R7

endmodule

// File: rtl/swdh_engine.sv
`timescale 1ns/1ps
module swdh_engine
   import swdh_pkg::*;
#(
   parameter int CLK_DIV     = 2,
   parameter int IDLE_CYCLES = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid,
   input  logic         req_ap,
   input  logic         req_rd,
   input  logic [1:0]   req_addr,
   input  logic [31:0]  req_wdata,
   output logic         busy,
   output logic         done,
   output logic [31:0]  rsp_rdata,
   output logic [2:0]   rsp_ack,
   output logic         rsp_ack_err,
   output logic         rsp_par_err,
   output logic         swclk,
   output logic         swdio_out,
   output logic         swdio_oe,
   input  logic         swdio_in
);

   swdh_hdr_req_t             hreq;
   logic [SWDH_HDR_BITS-1:0]  hdr;
   logic                      rise_now, fall_now;

   assign hreq = '{ap: req_ap, rd: req_rd, addr: req_addr};

   swdh_hdr u_hdr (
      .req (hreq),
      .hdr (hdr)
   );

   swdh_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .swclk    (swclk),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   swdh_seq #(.IDLE_CYCLES(IDLE_CYCLES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_rd      (req_rd),
      .req_wdata   (req_wdata),
      .hdr         (hdr),
      .rise_now    (rise_now),
      .fall_now    (fall_now),
      .swdio_in    (swdio_in),
      .busy        (busy),
      .done        (done),
      .rsp_rdata   (rsp_rdata),
      .rsp_ack     (rsp_ack),
      .rsp_ack_err (rsp_ack_err),
      .rsp_par_err (rsp_par_err),
      .swdio_out   (swdio_out),
      .swdio_oe    (swdio_oe)
   );

   AST_LINE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      swclk |-> ($stable(swdio_out) && $stable(swdio_oe))); // R8
   AST_CLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !swclk); // R8

endmodule

// File: tb/swdh_engine_bench.sv
`timescale 1ns/1ps
module swdh_engine_bench;

   localparam int CLK_DIV = 2;
   localparam int IDLE    = 3;
   localparam int LOGN    = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_ap = 1'b0, req_rd = 1'b0;
   logic [1:0]  req_addr = 2'b00;
   logic [31:0] req_wdata = '0;
   logic        busy, done, rsp_ack_err, rsp_par_err, swclk, swdio_out, swdio_oe;
   logic [31:0] rsp_rdata;
   logic [2:0]  rsp_ack;
   logic        swdio_in = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   swdh_engine #(.CLK_DIV(CLK_DIV), .IDLE_CYCLES(IDLE)) u_swdh_engine (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ap(req_ap),
      .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack),
      .rsp_ack_err(rsp_ack_err), .rsp_par_err(rsp_par_err), .swclk(swclk),
      .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
   );

   int      checks = 0;
   int      fails  = 0;
   int      k      = 0;
   int      done_cnt = 0;
   logic    oe_log  [LOGN];
   logic    out_log [LOGN];
   logic    resp    [LOGN];
   realtime t_rise = 0.0;
   realtime high_w = 0.0;

   // target-side model: log host bits at each rising debug edge, answer on falling edges
   always @(posedge swclk) begin
      t_rise = $realtime;
      #1;
      if (k < LOGN) begin
         oe_log[k]  = swdio_oe;
         out_log[k] = swdio_out;
      end
      k++;
   end

   always @(negedge swclk) begin
      high_w   = $realtime - t_rise;
      swdio_in = (k < LOGN) ? resp[k] : 1'b0;
   end

   always @(posedge clk) if (done === 1'b1) done_cnt++;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_hdr(input logic ap, input logic rd, input logic [1:0] a);
      return {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
   endfunction

   function automatic logic [31:0] log_word(input int base, input int n);
      logic [31:0] w = '0;
      for (int i = 0; i < n; i++) w[i] = out_log[base + i];
      return w;
   endfunction

   function automatic bit oe_all(input int base, input int n, input logic v);
      for (int i = 0; i < n; i++) if (oe_log[base + i] !== v) return 1'b0;
      return 1'b1;
   endfunction

   task automatic plan(input logic [2:0] ack, input logic rd, input logic [31:0] rdata, input logic flip);
      for (int i = 0; i < LOGN; i++) resp[i] = 1'b0;
      for (int i = 0; i < 3; i++) resp[9 + i] = ack[i];
      if (rd && ack == 3'b001) begin
         for (int i = 0; i < 32; i++) resp[12 + i] = rdata[i];
         resp[44] = (^rdata) ^ flip;
      end
      for (int i = 0; i < LOGN; i++) begin oe_log[i] = 1'bx; out_log[i] = 1'bx; end
      k = 0;
      swdio_in = resp[0];
   endtask

   task automatic issue(input logic ap, input logic rd, input logic [1:0] a, input logic [31:0] wd);
      @(negedge clk);
      req_ap = ap; req_rd = rd; req_addr = a; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (done !== 1'b1 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (done !== 1'b1) chk(1'b0, "R10 watchdog", 0, 1);
   endtask

   task automatic chk_header(input string tag, input logic ap, input logic rd, input logic [1:0] a);
      logic [7:0] h = log_word(0, 8);
      chk(h == exp_hdr(ap, rd, a) && oe_all(0, 8, 1'b1), {tag, " R1 header"}, h, exp_hdr(ap, rd, a));
      chk(($countones(h[5:1]) % 2) == 0, {tag, " R2 header parity"}, h[5:1], 0);
   endtask

   task automatic t_reset();
      chk(busy === 1'b0 && done === 1'b0, "R10 reset idle", {busy, done}, 0);
      chk(swclk === 1'b0 && swdio_oe === 1'b1 && swdio_out === 1'b0, "R8 reset line",
          {swclk, swdio_oe, swdio_out}, 3'b010);
   endtask

   task automatic t_write_ok();
      logic [31:0] wd = 32'hA5C3_0F96;
      plan(3'b001, 1'b0, 0, 1'b0);
      issue(1'b1, 1'b0, 2'b01, wd);
      wait_done();
      chk_header("write", 1'b1, 1'b0, 2'b01);
      chk(oe_all(8, 5, 1'b0), "R3 R5 released trn+ack+trn", 0, 0);
      chk(rsp_ack == 3'b001 && rsp_ack_err == 1'b0, "R3 ack ok", {rsp_ack, rsp_ack_err}, 4'b0010);
      chk(log_word(13, 32) == wd && oe_all(13, 33, 1'b1), "R5 write word", log_word(13, 32), wd);
      chk(out_log[45] === ^wd, "R5 write parity", out_log[45], ^wd);
      chk(oe_all(46, IDLE, 1'b1) && log_word(46, IDLE) == 0, "R9 idle bits", log_word(46, IDLE), 0);
      chk(k == 46 + IDLE, "R9 bit count write", k, 46 + IDLE);
      chk(rsp_par_err == 1'b0, "R7 no parity error on write", rsp_par_err, 0);
      chk(high_w == CLK_DIV * 4.0, "R11 half period", int'(high_w), CLK_DIV * 4);
   endtask

   task automatic t_read(input logic ap, input logic [1:0] a, input logic [31:0] rd, input logic flip);
      plan(3'b001, 1'b1, rd, flip);
      issue(ap, 1'b1, a, 32'hDEAD_BEEF);
      wait_done();
      chk_header("read", ap, 1'b1, a);
      chk(oe_all(8, 38, 1'b0), "R6 released through read", 0, 0);
      chk(rsp_rdata == rd, "R6 read word", rsp_rdata, rd);
      chk(rsp_par_err == flip, "R7 parity flag", rsp_par_err, flip);
      chk(k == 46 + IDLE && oe_all(46, IDLE, 1'b1), "R9 R6 bit count read", k, 46 + IDLE);
   endtask

   task automatic t_bad_ack(input logic rd, input logic [2:0] ack);
      plan(ack, rd, 32'h5555_AAAA, 1'b0);
      issue(1'b0, rd, 2'b10, 32'hFFFF_FFFF);
      wait_done();
      chk(rsp_ack_err == 1'b1 && rsp_ack == ack, "R4 ack error", {rsp_ack, rsp_ack_err}, {ack, 1'b1});
      chk(k == 13 + IDLE, "R4 data phase skipped", k, 13 + IDLE);
      chk(oe_all(8, 5, 1'b0) && oe_all(13, IDLE, 1'b1) && log_word(13, IDLE) == 0,
          "R4 turnaround then idle", log_word(13, IDLE), 0);
      chk(rsp_rdata == 0 && rsp_par_err == 1'b0, "R4 no data result", {rsp_rdata, rsp_par_err}, 0);
   endtask

   task automatic t_ignore_busy();
      int d0;
      plan(3'b001, 1'b0, 0, 1'b0);
      issue(1'b0, 1'b0, 2'b00, 32'h0000_0001);
      d0 = done_cnt;
      repeat (20) @(negedge clk);
      chk(busy === 1'b1, "R10 busy during packet", busy, 1);
      req_ap = 1'b1; req_rd = 1'b1; req_addr = 2'b11; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done();
      repeat (40) @(negedge clk);
      chk_header("ignore", 1'b0, 1'b0, 2'b00);
      chk(done_cnt - d0 == 1 && k == 46 + IDLE && busy === 1'b0, "R10 busy request ignored",
          done_cnt - d0, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_ok();
      t_read(1'b0, 2'b11, 32'h1234_5678, 1'b0);
      t_read(1'b1, 2'b10, 32'hFFFF_0001, 1'b1);
      t_bad_ack(1'b0, 3'b010);
      t_bad_ack(1'b1, 3'b100);
      t_ignore_busy();
      @(negedge clk);
      chk(swclk === 1'b0 && swdio_oe === 1'b1 && swdio_out === 1'b0, "R8 idle line after packets",
          {swclk, swdio_oe, swdio_out}, 3'b010);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      chk(1'b0, "R10 global watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule